// File: doc/BRIEF.md
# Character Raster Timing and Refresh Address Generator

This block drives a character-cell raster display. It counts character clocks across each scanline, scanlines within each character row, and character rows within each frame. From these counts it produces horizontal and vertical sync, horizontal and vertical blanking, a display-enable strobe and a cursor strobe. Each clock it also presents the refresh address: a 14-bit character address for the screen buffer and a 5-bit row address that selects the scanline inside a glyph. Pixel serialisation, glyph lookup and colour are left to downstream logic.

A processor programs the block through two locations. Location 0 holds an index and location 1 is a data window onto the register the index selects. The character address restarts from the first cell of the current character row on every scanline, so a buffer row is fetched once per glyph scanline. It moves forward to the next buffer row only after the last glyph scanline. A light-pen strobe freezes the current character address in a latch, and the processor reads it back through the data window.

Top module: `crtc_top`

## Requirements
- R1: A write with `bus_sel`=0 loads the index from `bus_wdata[4:0]`. A write with `bus_sel`=1 loads the selected register. The registers are: 0 line total minus one, 1 displayed characters per line, 2 hsync start column, 3 sync widths (bits 3:0 horizontal in clocks, bits 7:4 vertical in scanlines), 4 rows per frame minus one (bits 6:0), 5 extra adjust scanlines (bits 4:0), 6 displayed rows (bits 6:0), 7 vsync row (bits 6:0), 8 mode (bit 0 = skew), 9 glyph height minus one (bits 4:0), 10 cursor first scanline, 11 cursor last scanline, 12/13 start address high (bits 5:0) and low, 14/15 cursor address high (bits 5:0) and low, 16/17 light-pen high (bits 5:0) and low. Only 14 to 17 read back; all other indices, and reads with `bus_sel`=0, return zero.
- R2: Inside a scanline the character address rises by one each clock and wraps modulo 2^14. The horizontal counter runs from 0 up to the line total register.
- R3: At the end of a scanline that is not the last glyph scanline, the row address rises by one and the character address returns to its value at the start of that scanline.
- R4: At the end of the last glyph scanline of a character row, the row address returns to 0 and the character address becomes the row's first address plus the displayed-characters count.
- R5: After the last row of the frame and then the adjust scanlines (row address counting 0 up), a new frame starts. The character address is loaded from the start register, and the row and row counters clear. The start register has no effect at any other time.
- R6: `hsync` is high for horizontal counts in [start, start+width). `vsync` is high on the first width scanlines of the vsync row. A width of zero gives no pulse.
- R7: `hblank` is high when the horizontal count is at or beyond the displayed count. `vblank` is high when the row count is at or beyond the displayed rows, or during adjust scanlines.
- R8: With skew 0, `disp_en` equals not `hblank` and not `vblank` in the same clock. With skew 1, it is that value delayed by one clock.
- R9: `cursor` is high inside the display area when the character address equals the cursor address and the row address lies within the cursor first and last scanlines, inclusive.
- R10: A `lpen_stb` pulse copies the character address into the light-pen latch if the latch is empty. Further strobes are ignored until a read of register 17 empties it.
- R11: After reset all counters, registers and addresses are zero, and `hsync` and `vsync` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = index location, 1 = data window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| lpen_stb | input | 1 | Light-pen capture strobe |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Display enable (optionally skewed) |
| cursor | output | 1 | Cursor strobe |
| char_addr | output | 14 | Character refresh address |
| row_addr | output | 5 | Glyph scanline address |

## Verification
The hardest case to reach is a register changed while the frame is running. Examples are a new start address or a shorter glyph height written mid-row, and the adjust count dropping under the running scanline count. These cases sit behind many clocks of counting. The stimulus programs random small geometries so that frames, adjust zones and 14-bit address wraps come round within a few hundred clocks. It then keeps writing random registers during the run, while a bench model, updated on the same clock edge as each write, predicts every output each cycle.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CA_W   = 14;
  localparam int RA_W   = 5;
  localparam int HC_W   = 8;
  localparam int VC_W   = 7;
  localparam int SW_W   = 4;
  localparam int IDX_W  = 5;
  localparam int NCFG   = 16;
  localparam int CFG_AW = $clog2(NCFG);

  localparam int RG_HTOT  = 0;
  localparam int RG_HDISP = 1;
  localparam int RG_HSPOS = 2;
  localparam int RG_SYNCW = 3;
  localparam int RG_VTOT  = 4;
  localparam int RG_VADJ  = 5;
  localparam int RG_VDISP = 6;
  localparam int RG_VSPOS = 7;
  localparam int RG_MODE  = 8;
  localparam int RG_MAXR  = 9;
  localparam int RG_CSTA  = 10;
  localparam int RG_CEND  = 11;
  localparam int RG_STH   = 12;
  localparam int RG_STL   = 13;
  localparam int RG_CURH  = 14;
  localparam int RG_CURL  = 15;
  localparam int RG_LPH   = 16;
  localparam int RG_LPL   = 17;

  typedef struct packed {
    logic [HC_W-1:0] htot;
    logic [HC_W-1:0] hdisp;
    logic [HC_W-1:0] hspos;
    logic [SW_W-1:0] hsw;
    logic [SW_W-1:0] vsw;
    logic [VC_W-1:0] vtot;
    logic [RA_W-1:0] vadj;
    logic [VC_W-1:0] vdisp;
    logic [VC_W-1:0] vspos;
    logic            skew;
    logic [RA_W-1:0] maxrow;
    logic [RA_W-1:0] cstart;
    logic [RA_W-1:0] cend;
    logic [CA_W-1:0] start;
    logic [CA_W-1:0] cur;
  } cfg_t;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cs,
  input  logic            bus_we,
  input  logic            bus_sel,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic            lpen_stb,
  input  logic [CA_W-1:0] cur_ma,
  output cfg_t            cfg
);
  logic [7:0]       regs_q [NCFG];
  logic [7:0]       regs_d [NCFG];
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CA_W-1:0]  lp_q, lp_d;
  logic             full_q, full_d;
  logic             wr_en, rd_clr;

  assign wr_en  = bus_cs && bus_we;
  assign rd_clr = bus_cs && !bus_we && bus_sel && (idx_q == IDX_W'(RG_LPL));

  always_comb begin
    regs_d = regs_q;
    idx_d  = idx_q;
    lp_d   = lp_q;
    full_d = full_q;
    if (wr_en && !bus_sel) idx_d = bus_wdata[IDX_W-1:0];
    if (wr_en && bus_sel && (idx_q < IDX_W'(NCFG)))
      regs_d[idx_q[CFG_AW-1:0]] = bus_wdata;
    if (rd_clr) full_d = 1'b0;
    if (lpen_stb && !full_q) begin
      lp_d   = cur_ma;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) regs_q[i] <= '0;
      idx_q  <= '0;
      lp_q   <= '0;
      full_q <= 1'b0;
    end else begin
      regs_q <= regs_d;
      idx_q  <= idx_d;
      lp_q   <= lp_d;
      full_q <= full_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (idx_q)
        IDX_W'(RG_CURH): bus_rdata = {2'b00, regs_q[RG_CURH][5:0]};
        IDX_W'(RG_CURL): bus_rdata = regs_q[RG_CURL];
        IDX_W'(RG_LPH):  bus_rdata = {2'b00, lp_q[CA_W-1:8]};
        IDX_W'(RG_LPL):  bus_rdata = lp_q[7:0];
        default:         bus_rdata = '0;
      endcase
    end
  end

  assign cfg.htot   = regs_q[RG_HTOT];
  assign cfg.hdisp  = regs_q[RG_HDISP];
  assign cfg.hspos  = regs_q[RG_HSPOS];
  assign cfg.hsw    = regs_q[RG_SYNCW][3:0];
  assign cfg.vsw    = regs_q[RG_SYNCW][7:4];
  assign cfg.vtot   = regs_q[RG_VTOT][VC_W-1:0];
  assign cfg.vadj   = regs_q[RG_VADJ][RA_W-1:0];
  assign cfg.vdisp  = regs_q[RG_VDISP][VC_W-1:0];
  assign cfg.vspos  = regs_q[RG_VSPOS][VC_W-1:0];
  assign cfg.skew   = regs_q[RG_MODE][0];
  assign cfg.maxrow = regs_q[RG_MAXR][RA_W-1:0];
  assign cfg.cstart = regs_q[RG_CSTA][RA_W-1:0];
  assign cfg.cend   = regs_q[RG_CEND][RA_W-1:0];
  assign cfg.start  = {regs_q[RG_STH][5:0], regs_q[RG_STL]};
  assign cfg.cur    = {regs_q[RG_CURH][5:0], regs_q[RG_CURL]};

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[7:IDX_W], regs_q[RG_VTOT][7], regs_q[RG_VADJ][7:5],
                         regs_q[RG_VDISP][7], regs_q[RG_VSPOS][7], regs_q[RG_MODE][7:1],
                         regs_q[RG_MAXR][7:5], regs_q[RG_CSTA][7:5], regs_q[RG_CEND][7:5],
                         regs_q[RG_STH][7:6], regs_q[RG_CURH][7:6]};

  // R10: a held light-pen value is not disturbed by further strobes
  assert_lpen_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd_clr) |=> $stable(lp_q));
  // R10: a strobe into an empty latch captures the address
  assert_lpen_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lpen_stb && !full_q) |=> (full_q && lp_q == $past(cur_ma)));
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_t            cfg,
  output logic [CA_W-1:0] ma,
  output logic [RA_W-1:0] ra,
  output logic            hde,
  output logic            vde,
  output logic            hsync,
  output logic            vsync
);
  logic [HC_W-1:0] h_q, h_d;
  logic [RA_W-1:0] r_q, r_d;
  logic [VC_W-1:0] v_q, v_d;
  logic            adj_q, adj_d;
  logic [CA_W-1:0] ma_q, ma_d, ls_q, ls_d;
  logic            eol, row_last, vlast, frame_end, enter_adj;
  logic [HC_W:0]   hs_end;

  assign eol       = (h_q >= cfg.htot);
  assign row_last  = adj_q ? (({1'b0, r_q} + 6'd1) >= {1'b0, cfg.vadj})
                           : (r_q >= cfg.maxrow);
  assign vlast     = (v_q >= cfg.vtot);
  assign frame_end = eol && row_last && (adj_q || (vlast && (cfg.vadj == '0)));
  assign enter_adj = eol && row_last && !adj_q && vlast && (cfg.vadj != '0);

  always_comb begin
    h_d   = eol ? '0 : h_q + HC_W'(1);
    r_d   = r_q;
    v_d   = v_q;
    adj_d = adj_q;
    ls_d  = ls_q;
    ma_d  = ma_q + CA_W'(1);
    if (eol) begin
      if (frame_end) begin
        r_d   = '0;
        v_d   = '0;
        adj_d = 1'b0;
        ma_d  = cfg.start;
        ls_d  = cfg.start;
      end else if (enter_adj) begin
        adj_d = 1'b1;
        r_d   = '0;
        ma_d  = ls_q;
      end else if (row_last) begin
        r_d  = '0;
        v_d  = v_q + VC_W'(1);
        ma_d = ls_q + CA_W'(cfg.hdisp);
        ls_d = ls_q + CA_W'(cfg.hdisp);
      end else begin
        r_d  = r_q + RA_W'(1);
        ma_d = ls_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      r_q   <= '0;
      v_q   <= '0;
      adj_q <= 1'b0;
      ma_q  <= '0;
      ls_q  <= '0;
    end else begin
      h_q   <= h_d;
      r_q   <= r_d;
      v_q   <= v_d;
      adj_q <= adj_d;
      ma_q  <= ma_d;
      ls_q  <= ls_d;
    end
  end

  assign hs_end = {1'b0, cfg.hspos} + (HC_W+1)'(cfg.hsw);
  assign hsync  = (h_q >= cfg.hspos) && ({1'b0, h_q} < hs_end);
  assign vsync  = !adj_q && (v_q == cfg.vspos) && (r_q < {1'b0, cfg.vsw});
  assign hde    = (h_q < cfg.hdisp);
  assign vde    = !adj_q && (v_q < cfg.vdisp);
  assign ma     = ma_q;
  assign ra     = r_q;

  logic unused_cfg;
  assign unused_cfg = ^{cfg.cur, cfg.cstart, cfg.cend, cfg.skew};

  // R2: linear advance inside a scanline
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !eol |=> (ma_q == $past(ma_q) + CA_W'(1)));
  // R3: scanline end inside a character row returns to the row's first address
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && !row_last) |=> (ma_q == $past(ls_q)));
  // R4: last glyph scanline moves on to the next buffer row
  assert_nextrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && row_last && !adj_q && !vlast) |=>
      (r_q == '0 && ma_q == $past(ls_q) + CA_W'($past(cfg.hdisp))));
  // R5: frame start loads the start register and clears the row
  assert_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (ma_q == $past(cfg.start) && r_q == '0 && v_q == '0 && !adj_q));
endmodule

// File: rtl/crtc_top.sv
module crtc_top
  import crtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cs,
  input  logic            bus_we,
  input  logic            bus_sel,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic            lpen_stb,
  output logic            hsync,
  output logic            vsync,
  output logic            hblank,
  output logic            vblank,
  output logic            disp_en,
  output logic            cursor,
  output logic [CA_W-1:0] char_addr,
  output logic [RA_W-1:0] row_addr
);
  cfg_t cfg;
  logic hde, vde, de_raw, de_q;

  crtc_regs regs_i (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lpen_stb(lpen_stb),
    .cur_ma(char_addr), .cfg(cfg)
  );

  crtc_timing timing_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .ma(char_addr), .ra(row_addr),
    .hde(hde), .vde(vde), .hsync(hsync), .vsync(vsync)
  );

  assign de_raw = hde && vde;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) de_q <= 1'b0;
    else        de_q <= de_raw;
  end

  assign hblank  = !hde;
  assign vblank  = !vde;
  assign disp_en = cfg.skew ? de_q : de_raw;
  assign cursor  = de_raw && (char_addr == cfg.cur) &&
                   (row_addr >= cfg.cstart) && (row_addr <= cfg.cend);

  // R8: with skew set, the enable follows the blanking state one clock late
  assert_skew_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.skew && $past(cfg.skew)) |-> (disp_en == $past(!hblank && !vblank)));
  // R9: the cursor only appears inside the display area
  assert_cursor_area_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cursor |-> (!hblank && !vblank));
endmodule

// File: tb/crtc_top_tb_top.sv
module crtc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 0, bus_we = 0, bus_sel = 0, lpen_stb = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic hsync, vsync, hblank, vblank, disp_en, cursor;
  logic [13:0] char_addr;
  logic [4:0] row_addr;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 0;
  logic [7:0] c [16];
  logic [4:0] bidx;

  int mh, mr, mv;
  bit madj, mdeq, mfull;
  logic [13:0] mma, mls, mlp;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lpen_stb(lpen_stb),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .disp_en(disp_en), .cursor(cursor), .char_addr(char_addr), .row_addr(row_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit f_hde(); return mh < int'(c[1]); endfunction
  function automatic bit f_vde(); return !madj && mv < int'(c[6][6:0]); endfunction

  // reference model of the requirements, advanced on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh <= 0; mr <= 0; mv <= 0; madj <= 0; mma <= '0; mls <= '0;
      mdeq <= 0; mfull <= 0; mlp <= '0;
    end else begin
      int ht, hd, vt, va, mx;
      bit eol, rl, vl;
      ht = int'(c[0]); hd = int'(c[1]); vt = int'(c[4][6:0]);
      va = int'(c[5][4:0]); mx = int'(c[9][4:0]);
      eol = mh >= ht;
      rl  = madj ? (mr + 1 >= va) : (mr >= mx);
      vl  = mv >= vt;
      mdeq <= f_hde() && f_vde();
      if (bus_cs && !bus_we && bus_sel && bidx == 5'd17 && mfull) mfull <= 0;
      if (lpen_stb && !mfull) begin mlp <= mma; mfull <= 1; end
      if (!eol) begin
        mh <= mh + 1; mma <= mma + 14'd1;
      end else begin
        mh <= 0;
        if (rl && (madj || (vl && va == 0))) begin
          mr <= 0; mv <= 0; madj <= 0;
          mma <= {c[12][5:0], c[13]}; mls <= {c[12][5:0], c[13]};
        end else if (rl && !madj && vl) begin
          madj <= 1; mr <= 0; mma <= mls;
        end else if (rl && !madj) begin
          mr <= 0; mv <= mv + 1;
          mma <= mls + 14'(hd); mls <= mls + 14'(hd);
        end else begin
          mr <= mr + 1; mma <= mls;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int hp, hw, vw;
      bit ehs, evs, ecur;
      hp = int'(c[2]); hw = int'(c[3][3:0]); vw = int'(c[3][7:4]);
      ehs  = (mh >= hp) && (mh < hp + hw);
      evs  = !madj && (mv == int'(c[7][6:0])) && (mr < vw);
      ecur = f_hde() && f_vde() && (mma == {c[14][5:0], c[15]}) &&
             (mr >= int'(c[10][4:0])) && (mr <= int'(c[11][4:0]));
      chk("R2 R3 R4 R5 char_addr", 32'(char_addr), 32'(mma));
      chk("R3 R4 R5 row_addr", 32'(row_addr), 32'(mr));
      chk("R6 hsync", 32'(hsync), 32'(ehs));
      chk("R6 vsync", 32'(vsync), 32'(evs));
      chk("R7 hblank", 32'(hblank), 32'(!f_hde()));
      chk("R7 vblank", 32'(vblank), 32'(!f_vde()));
      chk("R8 disp_en", 32'(disp_en), 32'(c[8][0] ? mdeq : (f_hde() && f_vde())));
      chk("R9 cursor", 32'(cursor), 32'(ecur));
    end
  end

  task automatic wr_idx(input int a);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_sel = 0; bus_wdata = 8'(a);
    @(posedge clk); bidx <= 5'(a);
    @(negedge clk); bus_cs = 0;
  endtask

  task automatic wr(input int a, input int d);
    wr_idx(a);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_sel = 1; bus_wdata = 8'(d);
    @(posedge clk); if (a < 16) c[a] <= 8'(d);
    @(negedge clk); bus_cs = 0;
  endtask

  task automatic rd(input int a, input bit sel, output logic [7:0] v);
    wr_idx(a);
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_sel = sel;
    #1 v = bus_rdata;
    @(posedge clk);
    @(negedge clk); bus_cs = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cmp_on = 0; bidx = '0;
    for (int i = 0; i < 16; i++) c[i] = '0;
    @(negedge clk); @(negedge clk); rst_n = 1; cmp_on = 1;
  endtask

  task automatic strobe();
    @(negedge clk); lpen_stb = 1;
    @(negedge clk); lpen_stb = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [13:0] exp_lp;
    int seed, ht, vt, mx;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    do_reset();
    // R11: reset state
    chk("R11 char_addr", 32'(char_addr), 0);
    chk("R11 row_addr", 32'(row_addr), 0);
    chk("R11 hsync", 32'(hsync), 0);
    chk("R11 vsync", 32'(vsync), 0);
    // R1: write-only and unknown indices read zero; cursor registers read back
    for (int i = 0; i < 14; i++) wr(i, 8'hA5 ^ i);
    for (int i = 0; i < 14; i++) begin rd(i, 1, v); chk("R1 write-only reads zero", 32'(v), 0); end
    rd(20, 1, v); chk("R1 unknown index reads zero", 32'(v), 0);
    wr(14, 8'hFF); wr(15, 8'h3C);
    rd(14, 1, v); chk("R1 cursor high readback", 32'(v), 32'h3F);
    rd(15, 1, v); chk("R1 cursor low readback", 32'(v), 32'h3C);
    rd(15, 0, v); chk("R1 index location reads zero", 32'(v), 0);

    // directed geometry: address wrap near 2^14, adjust lines, skew on
    do_reset();
    wr(0, 9); wr(1, 6); wr(2, 7); wr(3, 8'h22); wr(4, 3); wr(5, 2); wr(6, 3);
    wr(7, 2); wr(8, 1); wr(9, 2); wr(10, 1); wr(11, 2);
    wr(12, 8'h3F); wr(13, 8'hF6); wr(14, 8'h00); wr(15, 8'h01);
    repeat (400) @(posedge clk);
    // mid-frame start change takes effect only at the next frame (R5, checked by model)
    wr(13, 8'h10); wr(12, 8'h01);
    repeat (300) @(posedge clk);

    // R10: capture, hold against a second strobe, clear by reading the low byte
    @(negedge clk); exp_lp = char_addr; lpen_stb = 1;
    @(negedge clk); lpen_stb = 0;
    repeat (7) @(posedge clk);
    strobe();
    rd(16, 1, v); chk("R10 light-pen high byte held", 32'(v), 32'({2'b00, exp_lp[13:8]}));
    rd(17, 1, v); chk("R10 light-pen low byte held", 32'(v), 32'(exp_lp[7:0]));
    @(negedge clk); exp_lp = char_addr; lpen_stb = 1;
    @(negedge clk); lpen_stb = 0;
    rd(17, 1, v); chk("R10 recapture after read", 32'(v), 32'(exp_lp[7:0]));

    // random geometries with register writes during the run
    for (int k = 0; k < 8; k++) begin
      do_reset();
      ht = 6 + int'($urandom_range(0, 20));
      vt = int'($urandom_range(0, 5));
      mx = int'($urandom_range(0, 4));
      wr(0, ht); wr(1, $urandom_range(0, ht + 1)); wr(2, $urandom_range(0, ht));
      wr(3, {4'($urandom_range(0, 5)), 4'($urandom_range(0, 5))});
      wr(4, vt); wr(5, $urandom_range(0, 3)); wr(6, $urandom_range(0, vt + 1));
      wr(7, $urandom_range(0, vt)); wr(8, $urandom_range(0, 1)); wr(9, mx);
      wr(10, $urandom_range(0, mx)); wr(11, $urandom_range(0, mx));
      wr(12, (k % 2 == 1) ? 8'h3F : 8'($urandom)); wr(13, $urandom);
      wr(14, c[12]); wr(15, c[13] + 8'($urandom_range(0, 3)));
      for (int j = 0; j < 6; j++) begin
        repeat ($urandom_range(40, 160)) @(posedge clk);
        case ($urandom_range(0, 4))
          0: strobe();
          1: begin rd(17, 1, v); chk("R10 light-pen low byte", 32'(v), 32'(mlp[7:0])); end
          2: wr(13, $urandom);
          3: wr(9, $urandom_range(0, 4));
          default: wr(5, $urandom_range(0, 3));
        endcase
      end
    end

    cmp_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule